// File: doc/BRIEF.md
# Serial Slave Port with Ready/Busy Flow Control

This block is the device side of a four-wire synchronous serial port driven by a host microcontroller. The host frames each transaction with an active-low select, clocks command and sample bytes in on the data-in line, and reads reply bytes on the data-out line during the same clock edges. The serial clock idles high. Incoming bits are taken on rising clock edges, outgoing bits change on falling edges, and bytes travel most significant bit first.

Inside the chip, each received byte goes into a small first-in first-out queue. The consumer drains it with a valid/ready pair. Reply bytes are loaded ahead of time into a holding register. When the queue is full, or when the internal logic raises a hold request, the ready line to the host goes low. The host must then wait for it to go high again before it makes its next falling clock edge. An interrupt request from the internal logic is passed to the host on an active-low pin.

All serial inputs pass through synchronisers into the system clock domain. The system clock must run at least four times faster than the serial clock.

Top module: `spi_rdy_slave`

## Requirements
- R1: After reset, `spi_rdy` is high, `spi_irq_n` is high, `rx_valid` is low and `spi_miso` is high-impedance while `spi_cs_n` is high.
- R2: While `spi_cs_n` is low, every eight rising `spi_sclk` edges produce one received byte. The first bit sampled is bit 7 and the last is bit 0.
- R3: `spi_miso` is high-impedance whenever `spi_cs_n` is high and is driven (0 or 1) whenever it is low.
- R4: The byte in the transmit holding register when select falls appears on `spi_miso` bit 7 first, one bit per falling `spi_sclk` edge. At each byte boundary (eighth rising edge) the holding register is copied again for the next byte. `tx_load` high for one cycle writes `tx_data` into the holding register.
- R5: Received bytes leave on `rx_data` in arrival order. A byte is removed in a cycle where `rx_valid` and `rx_ready` are both high. While `rx_valid` is high and `rx_ready` is low, `rx_data` holds still.
- R6: `spi_rdy` goes low within five system cycles after the last rising clock edge of a byte that fills the queue (RX_DEPTH bytes). It returns high two cycles after a byte is removed.
- R7: `hold_req` high in a cycle drives `spi_rdy` low in the next cycle.
- R8: Select rising before the eighth rising edge of a byte discards the partial byte. The next transaction starts again at bit 7.
- R9: A byte that completes while the queue already holds RX_DEPTH bytes is dropped. The queued bytes are unchanged.
- R10: `spi_irq_n` is the inverse of `irq_req`, registered once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from host, idles high |
| spi_cs_n | input | 1 | Active-low transaction select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, high-impedance when not selected |
| spi_rdy | output | 1 | High = ready, low = host must wait before next falling edge |
| spi_irq_n | output | 1 | Active-low interrupt to host |
| irq_req | input | 1 | Internal interrupt request |
| hold_req | input | 1 | Internal request to stall the host |
| tx_data | input | DATA_W | Next reply byte |
| tx_load | input | 1 | Writes tx_data into the holding register |
| rx_data | output | DATA_W | Oldest received byte |
| rx_valid | output | 1 | rx_data holds a byte |
| rx_ready | input | 1 | Consumer takes rx_data |

## Verification
The bench targets these corner cases:
- **Exactly full queue.** It fills the queue exactly and checks that ready drops only then. A design that counted one byte off would either stall too early or let the host overrun the queue.
- **Overrun.** It sends one byte past a full queue while ignoring ready. A design that overwrote a slot would lose or reorder the queued bytes.
- **Select abort.** It ends a transaction after three bits. A bit counter that was not cleared would misalign every later byte.
- **Two-byte reply.** It loads a new reply byte during the first byte of a two-byte reply. A design that reloaded the shifter on the wrong edge would repeat or shift that reply.

// File: rtl/spi_rdy_pkg.sv
package spi_rdy_pkg;
  // Serial-side events after synchronisation, one system cycle wide
  typedef struct packed {
    logic rise;      // rising sclk while selected
    logic fall;      // falling sclk while selected
    logic sel;       // select active
    logic sel_fall;  // select just became active
    logic mosi;      // synchronised data-in, aligned with rise
  } spi_evt_t;
endpackage

// File: rtl/spi_rdy_sync.sv
module spi_rdy_sync
  import spi_rdy_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     spi_sclk,
  input  logic     spi_cs_n,
  input  logic     spi_mosi,
  output spi_evt_t evt
);
  logic [SYNC_STAGES-1:0] sclk_p, cs_p, mosi_p;
  logic sclk_d, cs_d;
  logic sclk_s, cs_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p <= '1;
      cs_p   <= '1;
      mosi_p <= '0;
      sclk_d <= 1'b1;
      cs_d   <= 1'b1;
    end else begin
      sclk_p <= {sclk_p[SYNC_STAGES-2:0], spi_sclk};
      cs_p   <= {cs_p[SYNC_STAGES-2:0], spi_cs_n};
      mosi_p <= {mosi_p[SYNC_STAGES-2:0], spi_mosi};
      sclk_d <= sclk_p[SYNC_STAGES-1];
      cs_d   <= cs_p[SYNC_STAGES-1];
    end
  end

  assign sclk_s = sclk_p[SYNC_STAGES-1];
  assign cs_s   = cs_p[SYNC_STAGES-1];

  always_comb begin
    evt.sel      = ~cs_s;
    evt.sel_fall = ~cs_s & cs_d;
    evt.rise     = ~cs_s & sclk_s & ~sclk_d;
    evt.fall     = ~cs_s & ~sclk_s & sclk_d;
    evt.mosi     = mosi_p[SYNC_STAGES-1];
  end
endmodule

// File: rtl/spi_rdy_shift.sv
module spi_rdy_shift
  import spi_rdy_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  spi_evt_t          evt,
  input  logic [DATA_W-1:0] tx_hold,
  output logic              miso_q,
  output logic              done_q,
  output logic [DATA_W-1:0] byte_q
);
  localparam int CW = $clog2(DATA_W);
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] rx_sr;
  logic [DATA_W-1:0] tx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      rx_sr  <= '0;
      tx_sr  <= '0;
      miso_q <= 1'b0;
      done_q <= 1'b0;
      byte_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!evt.sel) begin
        cnt <= '0;  // partial byte is abandoned
      end else begin
        if (evt.sel_fall) begin
          tx_sr <= tx_hold;
          cnt   <= '0;
        end
        if (evt.rise) begin
          rx_sr <= {rx_sr[DATA_W-2:0], evt.mosi};
          if (cnt == LAST) begin
            cnt    <= '0;
            done_q <= 1'b1;
            byte_q <= {rx_sr[DATA_W-2:0], evt.mosi};
            tx_sr  <= tx_hold;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        if (evt.fall) begin
          miso_q <= tx_sr[DATA_W-1];
          tx_sr  <= {tx_sr[DATA_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_rdy_fifo.sv
module spi_rdy_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] din,
  input  logic              rd,
  output logic [DATA_W-1:0] dout,
  output logic              not_empty,
  output logic              full
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] CAP = (AW + 1)'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [AW:0]       count;
  logic              wr_en, rd_en;

  assign wr_en = wr & (count != CAP);
  assign rd_en = rd & (count != '0);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= rd_ptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout      = mem[rd_ptr];
  assign not_empty = (count != '0);
  assign full      = (count == CAP);
endmodule

// File: rtl/spi_rdy_slave.sv
module spi_rdy_slave
  import spi_rdy_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int RX_DEPTH    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_rdy,
  output logic              spi_irq_n,
  input  logic              irq_req,
  input  logic              hold_req,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_load,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready
);
  spi_evt_t          evt;
  logic              miso_q, done_q, q_full;
  logic [DATA_W-1:0] byte_q;
  logic [DATA_W-1:0] tx_hold;
  logic              rdy_q, irq_n_q;

  spi_rdy_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .evt(evt)
  );

  spi_rdy_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .evt(evt), .tx_hold(tx_hold),
    .miso_q(miso_q), .done_q(done_q), .byte_q(byte_q)
  );

  spi_rdy_fifo #(.DATA_W(DATA_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .wr(done_q), .din(byte_q),
    .rd(rx_ready), .dout(rx_data), .not_empty(rx_valid), .full(q_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_hold <= '0;
      rdy_q   <= 1'b1;
      irq_n_q <= 1'b1;
    end else begin
      if (tx_load) tx_hold <= tx_data;
      rdy_q   <= ~(q_full | hold_req);
      irq_n_q <= ~irq_req;
    end
  end

  assign spi_rdy   = rdy_q;
  assign spi_irq_n = irq_n_q;
  assign spi_miso  = spi_cs_n ? 1'bz : miso_q;
endmodule

// File: rtl/spi_rdy_slave_chk.sv
module spi_rdy_slave_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              spi_rdy,
  input logic              spi_irq_n,
  input logic              irq_req,
  input logic              hold_req,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              rx_ready
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (spi_rdy && spi_irq_n && !rx_valid));

  assert_data_held_R5: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  assert_busy_has_data_R6: assert property (@(posedge clk) disable iff (rst)
    (!spi_rdy && !$past(hold_req)) |-> rx_valid);

  assert_hold_stalls_R7: assert property (@(posedge clk) disable iff (rst)
    hold_req |=> !spi_rdy);

  assert_irq_on_R10: assert property (@(posedge clk) disable iff (rst)
    irq_req |=> !spi_irq_n);

  assert_irq_off_R10: assert property (@(posedge clk) disable iff (rst)
    !irq_req |=> spi_irq_n);
endmodule

bind spi_rdy_slave spi_rdy_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .spi_rdy(spi_rdy), .spi_irq_n(spi_irq_n),
  .irq_req(irq_req), .hold_req(hold_req), .rx_data(rx_data),
  .rx_valid(rx_valid), .rx_ready(rx_ready)
);

// File: tb/spi_rdy_slave_tb.sv
module spi_rdy_slave_tb;
  localparam int DW    = 8;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sclk = 1'b1, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  wire  spi_miso;
  logic spi_rdy, spi_irq_n;
  logic irq_req = 1'b0, hold_req = 1'b0;
  logic [DW-1:0] tx_data = '0;
  logic tx_load = 1'b0;
  logic [DW-1:0] rx_data;
  logic rx_valid;
  logic rx_ready = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_rdy_slave #(.DATA_W(DW), .RX_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_rdy(spi_rdy),
    .spi_irq_n(spi_irq_n), .irq_req(irq_req), .hold_req(hold_req),
    .tx_data(tx_data), .tx_load(tx_load), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready)
  );

  function automatic logic [DW-1:0] rnd_byte();
    return DW'($urandom);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_tx(input logic [DW-1:0] b);
    tx_data = b; tx_load = 1'b1; tick(1); tx_load = 1'b0;
  endtask

  task automatic cs_begin();
    spi_cs_n = 1'b0; tick(4);
  endtask

  task automatic cs_end();
    tick(4); spi_cs_n = 1'b1; tick(6);
  endtask

  task automatic wait_ready();
    int g = 0;
    while (!spi_rdy && g < 3000) begin tick(1); g++; end
    if (g >= 3000) chk(1'b0, "R6 ready never returned", 0, 1);
  endtask

  task automatic xfer(input logic [DW-1:0] mo, input logic [DW-1:0] next_tx,
                      input bit honor, output logic [DW-1:0] mi);
    if (honor) wait_ready();
    for (int i = DW - 1; i >= 0; i--) begin
      spi_sclk = 1'b0; spi_mosi = mo[i];
      tick(1);
      if (i == DW - 1) begin tx_data = next_tx; tx_load = 1'b1; end
      tick(1);
      tx_load = 1'b0;
      tick(2);
      mi[i] = spi_miso;
      spi_sclk = 1'b1;
      tick(4);
    end
    tick(6);
  endtask

  task automatic pop_expect(input logic [DW-1:0] exp, input string req);
    chk(rx_valid === 1'b1, req, int'(rx_valid), 1);
    chk(rx_data === exp, req, int'(rx_data), int'(exp));
    rx_ready = 1'b1; tick(1); rx_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] mi;
    logic [DW-1:0] rxb [DEPTH];
    logic [DW-1:0] txb [DEPTH];
    int unsigned seed;
    seed = $urandom(32'h5EED_0017);
    tick(5);
    rst = 1'b0;
    tick(1);

    // R1 / R3 reset state
    chk(spi_rdy === 1'b1,   "R1 rdy after reset", int'(spi_rdy), 1);
    chk(spi_irq_n === 1'b1, "R1 irq_n after reset", int'(spi_irq_n), 1);
    chk(rx_valid === 1'b0,  "R1 rx_valid after reset", int'(rx_valid), 0);
    chk(spi_miso === 1'bz,  "R1 R3 miso z while deselected", int'(spi_miso), 0);

    // R2 R4 R5 two-byte transaction with reply reload
    load_tx(8'hA5);
    cs_begin();
    chk(spi_miso !== 1'bz && spi_miso !== 1'bx, "R3 miso driven when selected", 0, 1);
    xfer(8'h3C, 8'h81, 1'b1, mi);
    chk(mi === 8'hA5, "R4 first reply byte", int'(mi), 8'hA5);
    xfer(8'hC3, 8'h00, 1'b1, mi);
    chk(mi === 8'h81, "R4 reloaded reply byte", int'(mi), 8'h81);
    cs_end();
    chk(spi_miso === 1'bz, "R3 miso z after deselect", 0, 0);
    tick(20);
    pop_expect(8'h3C, "R2 R5 first byte held and ordered");
    pop_expect(8'hC3, "R2 R5 second byte");
    chk(rx_valid === 1'b0, "R5 queue empty", int'(rx_valid), 0);

    // R6 fill, R9 overrun
    cs_begin();
    for (int k = 0; k < DEPTH; k++) begin
      rxb[k] = 8'h10 + DW'(k * 17);
      xfer(rxb[k], 8'h00, 1'b1, mi);
      if (k == DEPTH - 2) chk(spi_rdy === 1'b1, "R6 ready before full", int'(spi_rdy), 1);
    end
    chk(spi_rdy === 1'b0, "R6 busy when full", int'(spi_rdy), 0);
    xfer(8'hEE, 8'h00, 1'b0, mi);
    cs_end();
    pop_expect(rxb[0], "R9 head intact after overrun");
    tick(2);
    chk(spi_rdy === 1'b1, "R6 ready after pop", int'(spi_rdy), 1);
    for (int k = 1; k < DEPTH; k++) pop_expect(rxb[k], "R9 queued bytes intact");
    chk(rx_valid === 1'b0, "R9 overrun byte dropped", int'(rx_valid), 0);

    // R8 aborted byte
    cs_begin();
    for (int i = 0; i < 3; i++) begin
      spi_sclk = 1'b0; spi_mosi = 1'b1; tick(4);
      spi_sclk = 1'b1; tick(4);
    end
    cs_end();
    chk(rx_valid === 1'b0, "R8 partial byte discarded", int'(rx_valid), 0);
    cs_begin();
    xfer(8'h5A, 8'h00, 1'b1, mi);
    cs_end();
    pop_expect(8'h5A, "R8 fresh byte after abort");

    // R7 hold request
    hold_req = 1'b1; tick(1);
    chk(spi_rdy === 1'b0, "R7 hold forces busy", int'(spi_rdy), 0);
    hold_req = 1'b0; tick(1);
    chk(spi_rdy === 1'b1, "R7 ready after hold", int'(spi_rdy), 1);

    // R10 interrupt
    irq_req = 1'b1; tick(1);
    chk(spi_irq_n === 1'b0, "R10 irq asserted", int'(spi_irq_n), 0);
    irq_req = 1'b0; tick(1);
    chk(spi_irq_n === 1'b1, "R10 irq released", int'(spi_irq_n), 1);

    // Random transactions: R2 R4 R5
    for (int t = 0; t < 25; t++) begin
      int n;
      n = 1 + int'($urandom % DEPTH);
      for (int k = 0; k < n; k++) begin rxb[k] = rnd_byte(); txb[k] = rnd_byte(); end
      load_tx(txb[0]);
      cs_begin();
      for (int k = 0; k < n; k++) begin
        xfer(rxb[k], (k + 1 < n) ? txb[(k + 1) % DEPTH] : 8'h00, 1'b1, mi);
        chk(mi === txb[k], "R4 random reply", int'(mi), int'(txb[k]));
      end
      cs_end();
      tick(int'($urandom % 8));
      for (int k = 0; k < n; k++) pop_expect(rxb[k], "R2 R5 random receive");
      chk(rx_valid === 1'b0, "R5 random drain", int'(rx_valid), 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule